// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block reprograms one of several PLLs in a safe order when a request arrives. A request names the target PLL and gives the reference divider NR, the feedback multiplier NF and the output divider NO as plain values. The block first checks them against the legal range of the VCO and the output. It then moves the PLL's downstream clock onto the 24 MHz reference and holds the PLL in reset. Next it writes the divider fields, each stored as its value minus one. It waits a settle time of at least 10 µs, releases reset and polls that PLL's lock bit. Once lock is seen, it returns the PLL to normal mode.

The divider fields, the reset lines and the per-PLL mode are outputs of the block, so they drive the analog PLL macros directly. A second request type puts one PLL into deep low-power mode. A combinational readback port reports the output rate of any selected PLL, and that rate depends on the PLL's mode. If lock is not seen within a bounded number of cycles, the sequence is abandoned and the PLL stays on the reference clock.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset, `busy` and `err_pulse` are 0, every PLL mode is slow (2'b00), every `pll_rst` bit is 0 and every divider field is 0.
- R2: An idle programming request is rejected when any of the following holds:
  - NR, NF or NO is 0 or above its field range (64, 8192, 16).
  - NO is neither 1 nor even.
  - 24 MHz·NF/NR lies outside 440–2200 MHz.
  - That VCO rate divided by NO lies outside 30–2200 MHz.

  A rejection gives `err_pulse` high for exactly the cycle after the request edge and changes no other output.
- R3: After an accepted request, the following happen on successive edges:
  - The first edge after acceptance sets the PLL's mode to slow.
  - The second edge sets its `pll_rst` bit.
  - The third edge writes the divider fields.
  - `pll_rst` then stays high for SETTLE_CYC = CLK_HZ/100000 more cycles and is then cleared.
- R4: The fields are written as ref = NR-1 (6 bits), out = NO-1 (4 bits) and fb = NF-1 (13 bits). The bandwidth field (12 bits) is written with NF/2-1 only when `req_bw_en` was high with the request; otherwise it keeps its old value.
- R5: Once reset is released, `lock_in[p]` is sampled on each edge. Lock PLL `p` uses bit p of `lock_in`. The edge that sees it high sets the mode to normal (2'b01) and clears `busy`.
- R6: If lock is not seen on LOCK_TIMEOUT consecutive edges, the block ends the sequence. `err_pulse` rises for one cycle, `busy` clears and the mode stays slow.
- R7: `busy` is high from the cycle after acceptance until the sequence ends. While busy, requests are ignored and produce no error.
- R8: An idle request with `req_deep` high sets that PLL's mode to deep (2'b10) in one edge. It does no range check, does not raise `busy` and does not touch the fields.
- R9: `rd_rate_hz` for PLL `rd_pll` depends on its mode:
  - 24000000 in slow mode.
  - floor(24000000·(fb+1)/((ref+1)·(out+1))) in normal mode.
  - 32768 in deep mode.
- R10: A request alters only the mode, reset bit and fields of the PLL it names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_deep | input | 1 | Request deep mode instead of reprogramming |
| req_pll | input | 2 | Target PLL index |
| req_nr | input | 7 | Reference divider NR |
| req_nf | input | 14 | Feedback multiplier NF |
| req_no | input | 5 | Output divider NO |
| req_bw_en | input | 1 | Also write the bandwidth field |
| lock_in | input | 4 | Lock status, bit p for PLL p |
| rd_pll | input | 2 | PLL chosen for rate readback |
| busy | output | 1 | Sequence in progress |
| err_pulse | output | 1 | One-cycle rejection or timeout flag |
| pll_mode | output | 8 | Two-bit mode per PLL, PLL p at bits 2p+1:2p |
| pll_rst | output | 4 | Reset line per PLL |
| cfg_ref_div | output | 24 | NR-1 per PLL, 6 bits each |
| cfg_out_div | output | 16 | NO-1 per PLL, 4 bits each |
| cfg_fb_div | output | 52 | NF-1 per PLL, 13 bits each |
| cfg_bw | output | 48 | Bandwidth field per PLL, 12 bits each |
| rd_rate_hz | output | 32 | Output rate of PLL rd_pll in Hz |

## Verification
The request patterns form several groups:
- Legal settings for different PLLs, with and without the bandwidth field. These separate the field encodings and show that neighbouring PLLs stay untouched.
- One setting for each rejection cause: zero NR, odd NO, VCO too slow, VCO too fast and output too slow.
- A setting exactly on the 30 MHz output floor, which shows that the limits are inclusive.

A PLL whose lock never comes tells a timeout apart from a normal finish. A request issued mid-sequence shows that busy requests are dropped without an error. A deep-mode request, followed by readback in all three modes, covers each branch of the rate formula.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    typedef enum logic [1:0] {
        MODE_SLOW   = 2'b00,
        MODE_NORMAL = 2'b01,
        MODE_DEEP   = 2'b10
    } pll_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SLOW,
        ST_RESET,
        ST_PROG,
        ST_SETTLE,
        ST_LOCK
    } seq_state_e;

endpackage

// File: rtl/pll_req_check.sv
module pll_req_check #(
    parameter int          NR_W       = 6,
    parameter int          NF_W       = 13,
    parameter int          NO_W       = 4,
    parameter logic [63:0] REF_HZ     = 64'd24000000,
    parameter logic [63:0] VCO_MIN_HZ = 64'd440000000,
    parameter logic [63:0] VCO_MAX_HZ = 64'd2200000000,
    parameter logic [63:0] OUT_MIN_HZ = 64'd30000000,
    parameter logic [63:0] OUT_MAX_HZ = 64'd2200000000
) (
    input  logic [NR_W:0] nr,
    input  logic [NF_W:0] nf,
    input  logic [NO_W:0] no,
    output logic          ok
);
    localparam logic [NR_W:0] NR_MAX = {1'b1, {NR_W{1'b0}}};
    localparam logic [NF_W:0] NF_MAX = {1'b1, {NF_W{1'b0}}};
    localparam logic [NO_W:0] NO_MAX = {1'b1, {NO_W{1'b0}}};

    logic [63:0] nr64, nf64, no64, vco_x_nr, span;
    logic        range_ok, odd_ok, vco_ok, out_ok;

    assign nr64     = 64'(nr);
    assign nf64     = 64'(nf);
    assign no64     = 64'(no);
    // reference rate times NF equals VCO rate times NR
    assign vco_x_nr = REF_HZ * nf64;
    assign span     = nr64 * no64;

    assign range_ok = (nr != '0) && (nr <= NR_MAX) &&
                      (nf != '0) && (nf <= NF_MAX) &&
                      (no != '0) && (no <= NO_MAX);
    assign odd_ok   = (no == {{NO_W{1'b0}}, 1'b1}) || !no[0];
    assign vco_ok   = (vco_x_nr >= VCO_MIN_HZ * nr64) && (vco_x_nr <= VCO_MAX_HZ * nr64);
    assign out_ok   = (vco_x_nr >= OUT_MIN_HZ * span) && (vco_x_nr <= OUT_MAX_HZ * span);
    assign ok       = range_ok && odd_ok && vco_ok && out_ok;
endmodule

// File: rtl/pll_rate_calc.sv
module pll_rate_calc #(
    parameter int          NR_W    = 6,
    parameter int          NF_W    = 13,
    parameter int          NO_W    = 4,
    parameter logic [63:0] REF_HZ  = 64'd24000000,
    parameter logic [31:0] DEEP_HZ = 32'd32768
) (
    input  logic [1:0]      mode,
    input  logic [NR_W-1:0] ref_m1,
    input  logic [NF_W-1:0] fb_m1,
    input  logic [NO_W-1:0] out_m1,
    output logic [31:0]     rate_hz
);
    import pll_seq_pkg::*;

    logic [63:0] num, den;

    assign num = REF_HZ * (64'(fb_m1) + 64'd1);
    assign den = (64'(ref_m1) + 64'd1) * (64'(out_m1) + 64'd1);

    always_comb begin
        case (mode)
            MODE_SLOW:   rate_hz = 32'(REF_HZ);
            MODE_NORMAL: rate_hz = 32'(num / den);
            default:     rate_hz = DEEP_HZ;
        endcase
    end
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq #(
    parameter int NUM_PLL      = 4,
    parameter int NR_W         = 6,
    parameter int NF_W         = 13,
    parameter int NO_W         = 4,
    parameter int BW_W         = 12,
    parameter int CLK_HZ       = 50000000,
    parameter int LOCK_TIMEOUT = 1000,
    localparam int IDX_W       = $clog2(NUM_PLL)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic                     req_deep,
    input  logic [IDX_W-1:0]         req_pll,
    input  logic [NR_W:0]            req_nr,
    input  logic [NF_W:0]            req_nf,
    input  logic [NO_W:0]            req_no,
    input  logic                     req_bw_en,
    input  logic [NUM_PLL-1:0]       lock_in,
    input  logic [IDX_W-1:0]         rd_pll,
    output logic                     busy,
    output logic                     err_pulse,
    output logic [2*NUM_PLL-1:0]     pll_mode,
    output logic [NUM_PLL-1:0]       pll_rst,
    output logic [NUM_PLL*NR_W-1:0]  cfg_ref_div,
    output logic [NUM_PLL*NO_W-1:0]  cfg_out_div,
    output logic [NUM_PLL*NF_W-1:0]  cfg_fb_div,
    output logic [NUM_PLL*BW_W-1:0]  cfg_bw,
    output logic [31:0]              rd_rate_hz
);
    import pll_seq_pkg::*;

    localparam int SETTLE_CYC = CLK_HZ / 100000;   // 10 us at CLK_HZ
    localparam int CNT_MAX    = (SETTLE_CYC > LOCK_TIMEOUT) ? SETTLE_CYC : LOCK_TIMEOUT;
    localparam int CNT_W      = $clog2(CNT_MAX + 1);

    typedef struct packed {
        seq_state_e                     st;
        logic [IDX_W-1:0]               idx;
        logic [NR_W-1:0]                nr_m1;
        logic [NF_W-1:0]                nf_m1;
        logic [NO_W-1:0]                no_m1;
        logic [BW_W-1:0]                bw;
        logic                           bw_en;
        logic [CNT_W-1:0]               cnt;
        logic                           err;
        logic [NUM_PLL-1:0][1:0]        mode;
        logic [NUM_PLL-1:0]             rst;
        logic [NUM_PLL-1:0][NR_W-1:0]   ref_div;
        logic [NUM_PLL-1:0][NO_W-1:0]   out_div;
        logic [NUM_PLL-1:0][NF_W-1:0]   fb_div;
        logic [NUM_PLL-1:0][BW_W-1:0]   bw_fld;
    } seq_t;

    seq_t s_d, s_q;
    logic req_ok;

    pll_req_check #(
        .NR_W (NR_W),
        .NF_W (NF_W),
        .NO_W (NO_W)
    ) u_check (
        .nr (req_nr),
        .nf (req_nf),
        .no (req_no),
        .ok (req_ok)
    );

    always_comb begin
        s_d     = s_q;
        s_d.err = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_deep) begin
                        s_d.mode[req_pll] = MODE_DEEP;
                    end else if (req_ok) begin
                        s_d.idx   = req_pll;
                        s_d.nr_m1 = req_nr[NR_W-1:0] - {{(NR_W-1){1'b0}}, 1'b1};
                        s_d.nf_m1 = req_nf[NF_W-1:0] - {{(NF_W-1){1'b0}}, 1'b1};
                        s_d.no_m1 = req_no[NO_W-1:0] - {{(NO_W-1){1'b0}}, 1'b1};
                        s_d.bw    = req_nf[BW_W:1] - {{(BW_W-1){1'b0}}, 1'b1};
                        s_d.bw_en = req_bw_en;
                        s_d.st    = ST_SLOW;
                    end else begin
                        s_d.err = 1'b1;
                    end
                end
            end
            ST_SLOW: begin
                s_d.mode[s_q.idx] = MODE_SLOW;
                s_d.st            = ST_RESET;
            end
            ST_RESET: begin
                s_d.rst[s_q.idx] = 1'b1;
                s_d.st           = ST_PROG;
            end
            ST_PROG: begin
                s_d.ref_div[s_q.idx] = s_q.nr_m1;
                s_d.out_div[s_q.idx] = s_q.no_m1;
                s_d.fb_div[s_q.idx]  = s_q.nf_m1;
                if (s_q.bw_en) begin
                    s_d.bw_fld[s_q.idx] = s_q.bw;
                end
                s_d.cnt = '0;
                s_d.st  = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (s_q.cnt == CNT_W'(SETTLE_CYC - 1)) begin
                    s_d.rst[s_q.idx] = 1'b0;
                    s_d.cnt          = '0;
                    s_d.st           = ST_LOCK;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_LOCK: begin
                if (lock_in[s_q.idx]) begin
                    s_d.mode[s_q.idx] = MODE_NORMAL;
                    s_d.st            = ST_IDLE;
                end else if (s_q.cnt == CNT_W'(LOCK_TIMEOUT - 1)) begin
                    s_d.err = 1'b1;
                    s_d.st  = ST_IDLE;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy      = (s_q.st != ST_IDLE);
    assign err_pulse = s_q.err;
    assign pll_rst   = s_q.rst;

    for (genvar g = 0; g < NUM_PLL; g++) begin : g_flat
        assign pll_mode[2*g +: 2]          = s_q.mode[g];
        assign cfg_ref_div[g*NR_W +: NR_W] = s_q.ref_div[g];
        assign cfg_out_div[g*NO_W +: NO_W] = s_q.out_div[g];
        assign cfg_fb_div[g*NF_W +: NF_W]  = s_q.fb_div[g];
        assign cfg_bw[g*BW_W +: BW_W]      = s_q.bw_fld[g];
    end

    pll_rate_calc #(
        .NR_W (NR_W),
        .NF_W (NF_W),
        .NO_W (NO_W)
    ) u_rate (
        .mode    (s_q.mode[rd_pll]),
        .ref_m1  (s_q.ref_div[rd_pll]),
        .fb_m1   (s_q.fb_div[rd_pll]),
        .out_m1  (s_q.out_div[rd_pll]),
        .rate_hz (rd_rate_hz)
    );
endmodule

// File: rtl/pll_reprog_seq_chk.sv
module pll_reprog_seq_chk #(
    parameter int NUM_PLL = 4,
    parameter int NF_W    = 13
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    busy,
    input logic                    err_pulse,
    input logic [2*NUM_PLL-1:0]    pll_mode,
    input logic [NUM_PLL-1:0]      pll_rst,
    input logic [NUM_PLL-1:0]      lock_in,
    input logic [NUM_PLL*NF_W-1:0] cfg_fb_div
);
    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    a_r3_single_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pll_rst));

    a_r7_idle_no_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (pll_rst == '0));

    a_r2_err_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> !busy);

    a_r4_fields_hold_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !$past(busy)) |-> $stable(cfg_fb_div));

    for (genvar i = 0; i < NUM_PLL; i++) begin : g_per_pll
        a_r3_reset_only_slow: assert property (@(posedge clk) disable iff (!rst_n)
            pll_rst[i] |-> (pll_mode[2*i +: 2] == 2'b00));

        a_r5_normal_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
            (seen_q && pll_mode[2*i +: 2] == 2'b01 && $past(pll_mode[2*i +: 2]) != 2'b01)
            |-> $past(lock_in[i]));
    end
endmodule

bind pll_reprog_seq pll_reprog_seq_chk #(
    .NUM_PLL (NUM_PLL),
    .NF_W    (NF_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .err_pulse  (err_pulse),
    .pll_mode   (pll_mode),
    .pll_rst    (pll_rst),
    .lock_in    (lock_in),
    .cfg_fb_div (cfg_fb_div)
);

// File: tb/pll_reprog_seq_tb.sv
`timescale 1ns/1ps
module pll_reprog_seq_tb_top;
    localparam int SETTLE = 500;
    localparam int TMO    = 1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_deep = 1'b0, req_bw_en = 1'b0;
    logic [1:0]  req_pll = '0, rd_pll = '0;
    logic [6:0]  req_nr = '0;
    logic [13:0] req_nf = '0;
    logic [4:0]  req_no = '0;
    logic [3:0]  lock_in = '0;
    logic        busy, err_pulse;
    logic [7:0]  pll_mode;
    logic [3:0]  pll_rst;
    logic [23:0] cfg_ref_div;
    logic [15:0] cfg_out_div;
    logic [51:0] cfg_fb_div;
    logic [47:0] cfg_bw;
    logic [31:0] rd_rate_hz;

    int  n_chk = 0, n_err = 0;
    bit  done = 0;

    always #10 clk = ~clk;

    pll_reprog_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_deep(req_deep),
        .req_pll(req_pll), .req_nr(req_nr), .req_nf(req_nf), .req_no(req_no),
        .req_bw_en(req_bw_en), .lock_in(lock_in), .rd_pll(rd_pll),
        .busy(busy), .err_pulse(err_pulse), .pll_mode(pll_mode), .pll_rst(pll_rst),
        .cfg_ref_div(cfg_ref_div), .cfg_out_div(cfg_out_div), .cfg_fb_div(cfg_fb_div),
        .cfg_bw(cfg_bw), .rd_rate_hz(rd_rate_hz)
    );

    task automatic chk(string tag, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference ----------------
    function automatic bit legal(int nr, int nf, int no);
        longint v;
        if (nr < 1 || nr > 64 || nf < 1 || nf > 8192 || no < 1 || no > 16) return 0;
        if (!(no == 1 || no % 2 == 0)) return 0;
        v = longint'(24000000) * nf;
        if (v < longint'(440000000) * nr || v > longint'(64'd2200000000) * nr) return 0;
        if (v < longint'(30000000) * nr * no || v > longint'(64'd2200000000) * nr * no) return 0;
        return 1;
    endfunction

    function automatic longint rate_of(int md, int rf, int fb, int od);
        if (md == 0) return 24000000;
        if (md == 1) return (longint'(24000000) * (fb + 1)) / ((rf + 1) * (od + 1));
        return 32768;
    endfunction

    int m_phase, m_p, m_wait;
    int m_nr, m_nf, m_no;
    bit m_bwen, m_err;
    int m_mode[4], m_rst[4], m_ref[4], m_od[4], m_fb[4], m_bw[4];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_err = 0;
            for (int i = 0; i < 4; i++) begin
                m_mode[i] = 0; m_rst[i] = 0; m_ref[i] = 0; m_od[i] = 0; m_fb[i] = 0; m_bw[i] = 0;
            end
        end else begin
            m_err = 0;
            if (m_phase == 0) begin
                if (req_valid) begin
                    if (req_deep) m_mode[req_pll] = 2;
                    else if (legal(int'(req_nr), int'(req_nf), int'(req_no))) begin
                        m_p = req_pll; m_nr = req_nr; m_nf = req_nf; m_no = req_no;
                        m_bwen = req_bw_en; m_phase = 1;
                    end else m_err = 1;
                end
            end else if (m_phase == 1) begin
                m_mode[m_p] = 0; m_phase = 2;
            end else if (m_phase == 2) begin
                m_rst[m_p] = 1; m_phase = 3;
            end else if (m_phase == 3) begin
                m_ref[m_p] = m_nr - 1; m_od[m_p] = m_no - 1; m_fb[m_p] = m_nf - 1;
                if (m_bwen) m_bw[m_p] = m_nf / 2 - 1;
                m_wait = 0; m_phase = 4;
            end else if (m_phase == 4) begin
                m_wait++;
                if (m_wait == SETTLE) begin m_rst[m_p] = 0; m_wait = 0; m_phase = 5; end
            end else begin
                if (lock_in[m_p]) begin m_mode[m_p] = 1; m_phase = 0; end
                else if (m_wait + 1 == TMO) begin m_err = 1; m_phase = 0; end
                else m_wait++;
            end
        end
    end

    // compare every cycle, away from the edge
    always @(posedge clk) begin
        #5;
        if (rst_n && !done) begin
            chk("R7 busy", longint'(busy), longint'(m_phase != 0));
            chk("R2 err_pulse", longint'(err_pulse), longint'(m_err));
            for (int i = 0; i < 4; i++) begin
                chk("R3 mode", longint'(pll_mode[2*i +: 2]), m_mode[i]);
                chk("R3 rst", longint'(pll_rst[i]), m_rst[i]);
                chk("R4 ref", longint'(cfg_ref_div[6*i +: 6]), m_ref[i]);
                chk("R4 out", longint'(cfg_out_div[4*i +: 4]), m_od[i]);
                chk("R4 fb", longint'(cfg_fb_div[13*i +: 13]), m_fb[i]);
                chk("R4 bw", longint'(cfg_bw[12*i +: 12]), m_bw[i]);
            end
            chk("R9 rate", longint'(rd_rate_hz),
                rate_of(m_mode[rd_pll], m_ref[rd_pll], m_fb[rd_pll], m_od[rd_pll]));
        end
    end

    // ---------------- PLL lock model ----------------
    int lk_cnt[4];
    int lk_dly[4] = '{3, 5, 2, 7};
    bit never[4];

    initial begin
        forever begin
            @(negedge clk);
            for (int i = 0; i < 4; i++) begin
                if (pll_rst[i] || never[i]) begin lk_cnt[i] = 0; lock_in[i] = 1'b0; end
                else if (lk_cnt[i] >= lk_dly[i]) lock_in[i] = 1'b1;
                else lk_cnt[i]++;
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic send(int p, int nr, int nf, int no, bit bw, bit deep);
        @(negedge clk);
        req_valid = 1'b1; req_pll = 2'(p); req_nr = 7'(nr); req_nf = 14'(nf);
        req_no = 5'(no); req_bw_en = bw; req_deep = deep;
        @(negedge clk);
        req_valid = 1'b0; req_deep = 1'b0;
    endtask

    task automatic wait_idle(int limit);
        for (int k = 0; k < limit && busy; k++) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 busy", longint'(busy), 0);
        chk("R1 err", longint'(err_pulse), 0);
        chk("R1 mode", longint'(pll_mode), 0);
        chk("R1 rst", longint'(pll_rst), 0);
        chk("R1 fb", longint'(cfg_fb_div), 0);
        rst_n = 1'b1;

        // legal request on PLL 1, bandwidth on
        send(1, 1, 50, 2, 1'b1, 1'b0);
        chk("R7 busy after accept", longint'(busy), 1);
        @(negedge clk);
        chk("R3 slow mode first", longint'(pll_mode[3:2]), 0);
        chk("R3 reset not yet", longint'(pll_rst[1]), 0);
        @(negedge clk);
        chk("R3 reset second", longint'(pll_rst[1]), 1);
        wait_idle(3000);
        chk("R5 normal after lock", longint'(pll_mode[3:2]), 1);
        chk("R4 fb NF-1", longint'(cfg_fb_div[25:13]), 49);
        chk("R4 bw NF/2-1", longint'(cfg_bw[23:12]), 24);
        chk("R10 neighbour mode", longint'(pll_mode[1:0]), 0);
        rd_pll = 2'd1;
        @(negedge clk);
        chk("R9 normal rate", longint'(rd_rate_hz), 600000000);

        // rejections
        send(2, 1, 50, 3, 1'b0, 1'b0);
        chk("R2 odd NO", longint'(err_pulse), 1);
        send(2, 1, 10, 1, 1'b0, 1'b0);
        chk("R2 VCO low", longint'(err_pulse), 1);
        send(2, 1, 100, 1, 1'b0, 1'b0);
        chk("R2 VCO high", longint'(err_pulse), 1);
        send(2, 1, 19, 16, 1'b0, 1'b0);
        chk("R2 output low", longint'(err_pulse), 1);
        send(2, 0, 50, 2, 1'b0, 1'b0);
        chk("R2 zero NR", longint'(err_pulse), 1);
        chk("R2 no state change", longint'(busy), 0);

        // inclusive boundary: 480 MHz VCO, 30 MHz out
        send(3, 1, 20, 16, 1'b1, 1'b0);
        chk("R2 boundary accepted", longint'(busy), 1);
        wait_idle(3000);

        // bandwidth off, plus a request while busy
        send(2, 1, 67, 1, 1'b0, 1'b0);
        send(0, 1, 50, 2, 1'b1, 1'b0);
        chk("R7 no error while busy", longint'(err_pulse), 0);
        wait_idle(3000);
        chk("R7 ignored request", longint'(cfg_fb_div[12:0]), 0);
        chk("R4 bw untouched", longint'(cfg_bw[35:24]), 0);
        chk("R5 pll2 normal", longint'(pll_mode[5:4]), 1);

        // deep mode
        send(3, 0, 0, 0, 1'b0, 1'b1);
        chk("R8 deep mode", longint'(pll_mode[7:6]), 2);
        chk("R8 no busy", longint'(busy), 0);
        rd_pll = 2'd3;
        @(negedge clk);
        chk("R9 deep rate", longint'(rd_rate_hz), 32768);

        // lock timeout on PLL 0
        never[0] = 1'b1;
        rd_pll = 2'd0;
        send(0, 9, 400, 2, 1'b0, 1'b0);
        wait_idle(3000);
        chk("R6 stays slow", longint'(pll_mode[1:0]), 0);
        chk("R6 busy cleared", longint'(busy), 0);
        chk("R9 slow rate", longint'(rd_rate_hz), 24000000);
        never[0] = 1'b0;
        send(0, 9, 400, 2, 1'b0, 1'b0);
        wait_idle(3000);
        chk("R5 pll0 normal", longint'(pll_mode[1:0]), 1);
        chk("R9 fractional rate", longint'(rd_rate_hz), 533333333);
        chk("R10 pll3 still deep", longint'(pll_mode[7:6]), 2);

        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule